// File: doc/BRIEF.md
# Instruction Buffer with Bypass and Squash

This block sits between two stages of an in-order pipeline. Each queued instruction carries a tag made of a thread number, a sequence number and a payload. When an instruction arrives, the block decides whether it may skip both the buffer and the following stage and go straight to the stage two ahead. The decision depends on three conditions: the buffer is empty, the stage two ahead is not stalled for the instruction's thread, and that stage's input queue has room. When any condition fails, the instruction is labelled for insertion one stage ahead and for removal two stages ahead.

The queue is first-in, first-out. It supports four operations: append at the tail, pop from the head, delete a given tag, and a selective squash. The squash discards the younger instructions of one thread. After a delete or a squash, the surviving entries close ranks toward the head in the same cycle and keep their order. Occupancy, full and empty are always visible, and so is the head entry.

Top module: `instr_bypass_buffer`

## Requirements
- R1: A synchronous active-high `rst` empties the queue. The next cycle shows `count`=0, `empty`=1, `full`=0, `head_valid`=0, and every response strobe low.
- R2: One cycle after `arr_valid`, `byp_valid` is 1. `byp_grant` is 1 only if all three hold in the arrival cycle: the queue was empty, `stg2_blocked[arr_tid]` was 0, and `stg2_free` was nonzero.
- R3: On a grant, `byp_next_stage` is `arr_stage`+2. On a denial, `byp_next_stage` and `byp_ins_stage` are `arr_stage`+1 and `byp_rem_stage` is `arr_stage`+2. All stage sums wrap modulo 2^STG_W.
- R4: An insert is accepted only when occupancy, after any removal in the same cycle, is below DEPTH. The next cycle, `ins_done`=1 and `ins_ok` tells whether the insert was accepted. `full` is 1 exactly when `count` equals DEPTH.
- R5: Accepted entries are appended at the tail. The head ports show the oldest entry. A pop removes the head and the remaining entries keep their order.
- R6: A pop on an empty queue changes nothing and returns `pop_done`=1 with `pop_ok`=0.
- R7: A delete request removes the first entry from the head whose thread and sequence number both match, and keeps the order of the rest. If nothing matches, the queue is unchanged and `rm_found`=0.
- R8: A squash removes every entry whose thread equals `sq_tid` and whose sequence number is strictly greater than `sq_seq` (unsigned compare). Entries of other threads, and entries with an equal or lower sequence number, stay in their original order. The new `count` is visible the next cycle.
- R9: When a squash and an insert arrive in the same cycle, the insert is checked against the occupancy after the squash. An inserted instruction of thread `sq_tid` with a sequence number above `sq_seq` is dropped, and `ins_ok`=0.
- R10: Squash, delete and pop are ranked in that order. When more than one is requested in a cycle, only the highest-ranked one acts. A lower-ranked delete reports `rm_found`=0, and a lower-ranked pop reports `pop_ok`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous reset, active high |
| arr_valid | input | 1 | an instruction arrives for a bypass decision |
| arr_tid | input | TID_W | thread of the arriving instruction |
| arr_stage | input | STG_W | stage currently holding the arriving instruction |
| stg2_blocked | input | NTHR | per-thread stall of the stage two ahead |
| stg2_free | input | FREE_W | free slots in the input queue of the stage two ahead |
| byp_valid | output | 1 | a bypass decision is presented |
| byp_grant | output | 1 | bypass granted |
| byp_next_stage | output | STG_W | next stage for the instruction |
| byp_ins_stage | output | STG_W | stage that inserts into the buffer (on a denial) |
| byp_rem_stage | output | STG_W | stage that removes from the buffer (on a denial) |
| ins_req | input | 1 | insert request |
| ins_tid | input | TID_W | thread of the entry to insert |
| ins_seq | input | SEQ_W | sequence number of the entry to insert |
| ins_pay | input | PAY_W | payload of the entry to insert |
| ins_done | output | 1 | insert response strobe |
| ins_ok | output | 1 | insert accepted |
| pop_req | input | 1 | pop-head request |
| pop_done | output | 1 | pop response strobe |
| pop_ok | output | 1 | pop removed an entry |
| rm_req | input | 1 | delete-by-tag request |
| rm_tid | input | TID_W | thread of the tag to delete |
| rm_seq | input | SEQ_W | sequence number of the tag to delete |
| rm_done | output | 1 | delete response strobe |
| rm_found | output | 1 | a matching entry was deleted |
| sq_req | input | 1 | squash request |
| sq_tid | input | TID_W | thread to squash |
| sq_seq | input | SEQ_W | squash point; strictly younger entries go |
| head_valid | output | 1 | the head entry is valid |
| head_tid | output | TID_W | thread of the head entry |
| head_seq | output | SEQ_W | sequence number of the head entry |
| head_pay | output | PAY_W | payload of the head entry |
| count | output | CNT_W | occupancy |
| full | output | 1 | occupancy equals DEPTH |
| empty | output | 1 | occupancy is zero |

## Verification
The bench builds the block with DEPTH=4, two threads, eight stage numbers and a three-bit free-slot count. At this size the bypass decision can be swept over every thread, every stall mask and every free-slot value, with the queue both empty and non-empty, including the wrap of the stage number. With only four entries, each squash point can be tried against a full queue of mixed threads, and the result is confirmed entry by entry by draining the queue. The same small size makes it easy to reach a full queue that a same-cycle squash then frees.

// File: rtl/ibuf_pkg.sv
package ibuf_pkg;
  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_SQUASH = 2'd1,
    OP_REMOVE = 2'd2,
    OP_POP    = 2'd3
  } ibuf_op_e;

  function automatic int id_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/ibuf_bypass_dec.sv
module ibuf_bypass_dec #(
  parameter int NTHR   = 2,
  parameter int TID_W  = 1,
  parameter int STG_W  = 3,
  parameter int FREE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arr_valid,
  input  logic [TID_W-1:0]  arr_tid,
  input  logic [STG_W-1:0]  arr_stage,
  input  logic [NTHR-1:0]   stg2_blocked,
  input  logic [FREE_W-1:0] stg2_free,
  input  logic              buf_empty,
  output logic              byp_valid,
  output logic              byp_grant,
  output logic [STG_W-1:0]  byp_next_stage,
  output logic [STG_W-1:0]  byp_ins_stage,
  output logic [STG_W-1:0]  byp_rem_stage
);
  logic             thr_stalled;
  logic             grant_d;
  logic [STG_W-1:0] stg_p1;
  logic [STG_W-1:0] stg_p2;

  always_comb begin
    thr_stalled = 1'b0;
    for (int t = 0; t < NTHR; t++) begin
      if (arr_tid == TID_W'(t)) thr_stalled = stg2_blocked[t];
    end
    grant_d = buf_empty && !thr_stalled && (stg2_free != '0);
    stg_p1  = arr_stage + STG_W'(1);
    stg_p2  = arr_stage + STG_W'(2);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      byp_valid      <= 1'b0;
      byp_grant      <= 1'b0;
      byp_next_stage <= '0;
      byp_ins_stage  <= '0;
      byp_rem_stage  <= '0;
    end else begin
      byp_valid <= arr_valid;
      if (arr_valid) begin
        byp_grant      <= grant_d;
        byp_next_stage <= grant_d ? stg_p2 : stg_p1;
        byp_ins_stage  <= stg_p1;
        byp_rem_stage  <= stg_p2;
      end else begin
        byp_grant <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ibuf_kill_mask.sv
module ibuf_kill_mask
  import ibuf_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int TID_W = 1,
  parameter int SEQ_W = 8,
  parameter int PAY_W = 16,
  parameter int CNT_W = 3,
  localparam int ENT_W = TID_W + SEQ_W + PAY_W
) (
  input  logic [DEPTH-1:0][ENT_W-1:0] ent,
  input  logic [CNT_W-1:0]            cnt,
  input  ibuf_op_e                    op,
  input  logic [TID_W-1:0]            sq_tid,
  input  logic [SEQ_W-1:0]            sq_seq,
  input  logic [TID_W-1:0]            rm_tid,
  input  logic [SEQ_W-1:0]            rm_seq,
  output logic [DEPTH-1:0]            keep,
  output logic [CNT_W-1:0]            kept_cnt,
  output logic                        rm_hit
);
  logic [DEPTH-1:0][TID_W-1:0] e_tid;
  logic [DEPTH-1:0][SEQ_W-1:0] e_seq;

  for (genvar g = 0; g < DEPTH; g++) begin : g_fields
    assign e_tid[g] = ent[g][ENT_W-1 -: TID_W];
    assign e_seq[g] = ent[g][PAY_W +: SEQ_W];
  end

  always_comb begin
    logic kill;
    logic vld;
    keep     = '0;
    kept_cnt = '0;
    rm_hit   = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      vld  = (CNT_W'(i) < cnt);
      kill = 1'b0;
      case (op)
        OP_SQUASH: kill = (e_tid[i] == sq_tid) && (e_seq[i] > sq_seq);
        OP_REMOVE: begin
          if (vld && !rm_hit && (e_tid[i] == rm_tid) && (e_seq[i] == rm_seq)) begin
            kill   = 1'b1;
            rm_hit = 1'b1;
          end
        end
        OP_POP:    kill = (i == 0);
        default:   kill = 1'b0;
      endcase
      keep[i]  = vld && !kill;
      kept_cnt = kept_cnt + CNT_W'(keep[i]);
    end
  end
endmodule

// File: rtl/ibuf_compact.sv
module ibuf_compact #(
  parameter int DEPTH = 4,
  parameter int ENT_W = 25,
  parameter int CNT_W = 3
) (
  input  logic [DEPTH-1:0][ENT_W-1:0] ent,
  input  logic [DEPTH-1:0]            keep,
  input  logic [CNT_W-1:0]            kept_cnt,
  input  logic                        ins_en,
  input  logic [ENT_W-1:0]            ins_ent,
  output logic [DEPTH-1:0][ENT_W-1:0] nxt_ent,
  output logic [CNT_W-1:0]            nxt_cnt
);
  logic [DEPTH-1:0][CNT_W-1:0] dest;

  always_comb begin
    logic [CNT_W-1:0] run;
    run = '0;
    for (int i = 0; i < DEPTH; i++) begin
      dest[i] = run;
      run     = run + CNT_W'(keep[i]);
    end
  end

  for (genvar j = 0; j < DEPTH; j++) begin : g_slot
    always_comb begin
      nxt_ent[j] = '0;
      for (int i = j; i < DEPTH; i++) begin
        if (keep[i] && dest[i] == CNT_W'(j)) nxt_ent[j] = ent[i];
      end
      if (ins_en && kept_cnt == CNT_W'(j)) nxt_ent[j] = ins_ent;
    end
  end

  assign nxt_cnt = kept_cnt + CNT_W'(ins_en);
endmodule

// File: rtl/instr_bypass_buffer.sv
module instr_bypass_buffer
  import ibuf_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int NTHR   = 2,
  parameter int SEQ_W  = 8,
  parameter int PAY_W  = 16,
  parameter int STG_W  = 3,
  parameter int FREE_W = 3,
  localparam int TID_W = id_width(NTHR),
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int ENT_W = TID_W + SEQ_W + PAY_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arr_valid,
  input  logic [TID_W-1:0]  arr_tid,
  input  logic [STG_W-1:0]  arr_stage,
  input  logic [NTHR-1:0]   stg2_blocked,
  input  logic [FREE_W-1:0] stg2_free,
  output logic              byp_valid,
  output logic              byp_grant,
  output logic [STG_W-1:0]  byp_next_stage,
  output logic [STG_W-1:0]  byp_ins_stage,
  output logic [STG_W-1:0]  byp_rem_stage,
  input  logic              ins_req,
  input  logic [TID_W-1:0]  ins_tid,
  input  logic [SEQ_W-1:0]  ins_seq,
  input  logic [PAY_W-1:0]  ins_pay,
  output logic              ins_done,
  output logic              ins_ok,
  input  logic              pop_req,
  output logic              pop_done,
  output logic              pop_ok,
  input  logic              rm_req,
  input  logic [TID_W-1:0]  rm_tid,
  input  logic [SEQ_W-1:0]  rm_seq,
  output logic              rm_done,
  output logic              rm_found,
  input  logic              sq_req,
  input  logic [TID_W-1:0]  sq_tid,
  input  logic [SEQ_W-1:0]  sq_seq,
  output logic              head_valid,
  output logic [TID_W-1:0]  head_tid,
  output logic [SEQ_W-1:0]  head_seq,
  output logic [PAY_W-1:0]  head_pay,
  output logic [CNT_W-1:0]  count,
  output logic              full,
  output logic              empty
);
  logic [DEPTH-1:0][ENT_W-1:0] ent_q;
  logic [DEPTH-1:0][ENT_W-1:0] nxt_ent;
  logic [CNT_W-1:0]            cnt_q;
  logic [CNT_W-1:0]            nxt_cnt;
  logic [DEPTH-1:0]            keep;
  logic [CNT_W-1:0]            kept_cnt;
  logic                        rm_hit;
  logic                        ins_young;
  logic                        ins_acc;
  ibuf_op_e                    op;

  // one structural operation per cycle, ranked squash > delete > pop
  always_comb begin
    if (sq_req)       op = OP_SQUASH;
    else if (rm_req)  op = OP_REMOVE;
    else if (pop_req) op = OP_POP;
    else              op = OP_NONE;
  end

  ibuf_bypass_dec #(
    .NTHR(NTHR), .TID_W(TID_W), .STG_W(STG_W), .FREE_W(FREE_W)
  ) u_dec (
    .clk(clk), .rst(rst),
    .arr_valid(arr_valid), .arr_tid(arr_tid), .arr_stage(arr_stage),
    .stg2_blocked(stg2_blocked), .stg2_free(stg2_free),
    .buf_empty(cnt_q == '0),
    .byp_valid(byp_valid), .byp_grant(byp_grant),
    .byp_next_stage(byp_next_stage), .byp_ins_stage(byp_ins_stage),
    .byp_rem_stage(byp_rem_stage)
  );

  ibuf_kill_mask #(
    .DEPTH(DEPTH), .TID_W(TID_W), .SEQ_W(SEQ_W), .PAY_W(PAY_W), .CNT_W(CNT_W)
  ) u_kill (
    .ent(ent_q), .cnt(cnt_q), .op(op),
    .sq_tid(sq_tid), .sq_seq(sq_seq), .rm_tid(rm_tid), .rm_seq(rm_seq),
    .keep(keep), .kept_cnt(kept_cnt), .rm_hit(rm_hit)
  );

  assign ins_young = (op == OP_SQUASH) && (ins_tid == sq_tid) && (ins_seq > sq_seq);
  assign ins_acc   = ins_req && !ins_young && (kept_cnt < CNT_W'(DEPTH));

  ibuf_compact #(
    .DEPTH(DEPTH), .ENT_W(ENT_W), .CNT_W(CNT_W)
  ) u_cmp (
    .ent(ent_q), .keep(keep), .kept_cnt(kept_cnt),
    .ins_en(ins_acc), .ins_ent({ins_tid, ins_seq, ins_pay}),
    .nxt_ent(nxt_ent), .nxt_cnt(nxt_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ent_q    <= '0;
      cnt_q    <= '0;
      ins_done <= 1'b0;
      ins_ok   <= 1'b0;
      pop_done <= 1'b0;
      pop_ok   <= 1'b0;
      rm_done  <= 1'b0;
      rm_found <= 1'b0;
    end else begin
      ent_q    <= nxt_ent;
      cnt_q    <= nxt_cnt;
      ins_done <= ins_req;
      ins_ok   <= ins_acc;
      pop_done <= pop_req;
      pop_ok   <= (op == OP_POP) && (cnt_q != '0);
      rm_done  <= rm_req;
      rm_found <= (op == OP_REMOVE) && rm_hit;
    end
  end

  assign head_valid = (cnt_q != '0);
  assign head_tid   = ent_q[0][ENT_W-1 -: TID_W];
  assign head_seq   = ent_q[0][PAY_W +: SEQ_W];
  assign head_pay   = ent_q[0][PAY_W-1:0];
  assign count      = cnt_q;
  assign full       = (cnt_q == CNT_W'(DEPTH));
  assign empty      = (cnt_q == '0);
endmodule

// File: rtl/instr_bypass_buffer_chk.sv
module instr_bypass_buffer_chk #(
  parameter int DEPTH  = 4,
  parameter int TID_W  = 1,
  parameter int STG_W  = 3,
  parameter int CNT_W  = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             arr_valid,
  input logic [STG_W-1:0] arr_stage,
  input logic             byp_valid,
  input logic             byp_grant,
  input logic [STG_W-1:0] byp_next_stage,
  input logic             ins_req,
  input logic             ins_done,
  input logic             ins_ok,
  input logic             pop_req,
  input logic             pop_done,
  input logic             pop_ok,
  input logic             rm_req,
  input logic             rm_found,
  input logic             sq_req,
  input logic [CNT_W-1:0] count,
  input logic             full,
  input logic             empty
);
  p_count_bound_r4: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));

  p_nonempty_denies_r2: assert property (@(posedge clk) disable iff (rst)
    arr_valid && !empty |=> byp_valid && !byp_grant);

  p_grant_stage_r3: assert property (@(posedge clk) disable iff (rst)
    arr_valid |=> (byp_next_stage == (byp_grant ? $past(arr_stage) + STG_W'(2)
                                                : $past(arr_stage) + STG_W'(1))));

  p_full_refuses_r4: assert property (@(posedge clk) disable iff (rst)
    ins_req && full && !sq_req && !rm_req && !pop_req |=> ins_done && !ins_ok);

  p_insert_grows_r5: assert property (@(posedge clk) disable iff (rst)
    ins_req && !full && !sq_req && !rm_req && !pop_req
      |=> ins_ok && count == $past(count) + CNT_W'(1));

  p_pop_empty_r6: assert property (@(posedge clk) disable iff (rst)
    pop_req && empty && !sq_req && !rm_req && !ins_req
      |=> pop_done && !pop_ok && empty);

  p_squash_shrinks_r8: assert property (@(posedge clk) disable iff (rst)
    sq_req && !ins_req |=> count <= $past(count));

  p_rank_r10: assert property (@(posedge clk) disable iff (rst)
    sq_req && (rm_req || pop_req) |=> !rm_found && !pop_ok);
endmodule

bind instr_bypass_buffer instr_bypass_buffer_chk #(
  .DEPTH(DEPTH), .TID_W(TID_W), .STG_W(STG_W), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/instr_bypass_buffer_bench.sv
`timescale 1ns/1ps
module instr_bypass_buffer_bench;
  localparam int DEPTH = 4;
  localparam int NTHR  = 2;
  localparam int SEQ_W = 8;
  localparam int PAY_W = 16;
  localparam int STG_W = 3;
  localparam int FREE_W = 3;
  localparam int TID_W = 1;
  localparam int CNT_W = 3;

  typedef struct packed {
    logic [TID_W-1:0] t;
    logic [SEQ_W-1:0] s;
    logic [PAY_W-1:0] p;
  } ment_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic arr_valid = 0; logic [TID_W-1:0] arr_tid = 0; logic [STG_W-1:0] arr_stage = 0;
  logic [NTHR-1:0] stg2_blocked = 0; logic [FREE_W-1:0] stg2_free = 0;
  logic byp_valid, byp_grant;
  logic [STG_W-1:0] byp_next_stage, byp_ins_stage, byp_rem_stage;
  logic ins_req = 0; logic [TID_W-1:0] ins_tid = 0; logic [SEQ_W-1:0] ins_seq = 0;
  logic [PAY_W-1:0] ins_pay = 0; logic ins_done, ins_ok;
  logic pop_req = 0; logic pop_done, pop_ok;
  logic rm_req = 0; logic [TID_W-1:0] rm_tid = 0; logic [SEQ_W-1:0] rm_seq = 0;
  logic rm_done, rm_found;
  logic sq_req = 0; logic [TID_W-1:0] sq_tid = 0; logic [SEQ_W-1:0] sq_seq = 0;
  logic head_valid; logic [TID_W-1:0] head_tid; logic [SEQ_W-1:0] head_seq;
  logic [PAY_W-1:0] head_pay; logic [CNT_W-1:0] count; logic full, empty;

  int checks = 0;
  int errors = 0;
  ment_t mq[$];

  always #10 clk = ~clk;

  instr_bypass_buffer #(
    .DEPTH(DEPTH), .NTHR(NTHR), .SEQ_W(SEQ_W), .PAY_W(PAY_W),
    .STG_W(STG_W), .FREE_W(FREE_W)
  ) u_instr_bypass_buffer (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_state(input string tag);
    chk({tag, " R4 count"}, int'(count), mq.size());
    chk({tag, " R4 full"}, int'(full), int'(mq.size() == DEPTH));
    chk({tag, " R5 empty"}, int'(empty), int'(mq.size() == 0));
    chk({tag, " R5 head_valid"}, int'(head_valid), int'(mq.size() != 0));
    if (mq.size() != 0) begin
      chk({tag, " R5 head_tid"}, int'(head_tid), int'(mq[0].t));
      chk({tag, " R5 head_seq"}, int'(head_seq), int'(mq[0].s));
      chk({tag, " R5 head_pay"}, int'(head_pay), int'(mq[0].p));
    end
  endtask

  // one cycle of queue operations, model applied per R8..R10 ranking
  task automatic step(input string tag,
                      input bit sq, input int st, input int ss,
                      input bit rm, input int rt, input int rs,
                      input bit pp,
                      input bit ins, input int it, input int is, input int ip);
    bit exp_found = 0, exp_pop = 0, exp_ins;
    ment_t nq[$];
    sq_req = sq; sq_tid = st[TID_W-1:0]; sq_seq = ss[SEQ_W-1:0];
    rm_req = rm; rm_tid = rt[TID_W-1:0]; rm_seq = rs[SEQ_W-1:0];
    pop_req = pp;
    ins_req = ins; ins_tid = it[TID_W-1:0]; ins_seq = is[SEQ_W-1:0]; ins_pay = ip[PAY_W-1:0];
    if (sq) begin
      foreach (mq[i]) if (!(int'(mq[i].t) == st && int'(mq[i].s) > ss)) nq.push_back(mq[i]);
      mq = nq;
    end else if (rm) begin
      for (int i = 0; i < mq.size(); i++) begin
        if (int'(mq[i].t) == rt && int'(mq[i].s) == rs) begin
          mq.delete(i); exp_found = 1; break;
        end
      end
    end else if (pp && mq.size() != 0) begin
      void'(mq.pop_front()); exp_pop = 1;
    end
    exp_ins = ins && mq.size() < DEPTH && !(sq && it == st && is > ss);
    if (exp_ins) mq.push_back('{t: it[TID_W-1:0], s: is[SEQ_W-1:0], p: ip[PAY_W-1:0]});
    @(posedge clk);
    @(negedge clk);
    sq_req = 0; rm_req = 0; pop_req = 0; ins_req = 0;
    chk({tag, " ins_done"}, int'(ins_done), int'(ins));
    chk({tag, " ins_ok"}, int'(ins_ok), int'(exp_ins));
    chk({tag, " pop_done"}, int'(pop_done), int'(pp));
    chk({tag, " pop_ok"}, int'(pop_ok), int'(exp_pop));
    chk({tag, " rm_done"}, int'(rm_done), int'(rm));
    chk({tag, " rm_found"}, int'(rm_found), int'(exp_found));
    check_state(tag);
  endtask

  task automatic ins1(input string tag, input int t, input int s, input int p);
    step(tag, 0, 0, 0, 0, 0, 0, 0, 1, t, s, p);
  endtask

  task automatic drain(input string tag);
    while (mq.size() != 0) step(tag, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
  endtask

  task automatic fill4();
    ins1("R5 fill", 0, 10, 16'h1100);
    ins1("R5 fill", 1, 20, 16'h2200);
    ins1("R5 fill", 0, 30, 16'h3300);
    ins1("R5 fill", 1, 40, 16'h4400);
  endtask

  task automatic byp(input int t, input int stg, input int mask, input int fr);
    bit g;
    g = (mq.size() == 0) && !mask[t] && fr != 0;
    arr_valid = 1; arr_tid = t[TID_W-1:0]; arr_stage = stg[STG_W-1:0];
    stg2_blocked = mask[NTHR-1:0]; stg2_free = fr[FREE_W-1:0];
    @(posedge clk);
    @(negedge clk);
    arr_valid = 0;
    chk("R2 byp_valid", int'(byp_valid), 1);
    chk("R2 byp_grant", int'(byp_grant), int'(g));
    chk("R3 next_stage", int'(byp_next_stage), (stg + (g ? 2 : 1)) % 8);
    if (!g) begin
      chk("R3 ins_stage", int'(byp_ins_stage), (stg + 1) % 8);
      chk("R3 rem_stage", int'(byp_rem_stage), (stg + 2) % 8);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk("watchdog R1", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1: reset state
    check_state("R1 reset");
    chk("R1 byp_valid", int'(byp_valid), 0);
    chk("R1 ins_done", int'(ins_done), 0);
    chk("R1 pop_done", int'(pop_done), 0);
    chk("R1 rm_done", int'(rm_done), 0);

    // R2/R3: sweep with an empty queue
    for (int t = 0; t < 2; t++)
      for (int m = 0; m < 4; m++)
        for (int f = 0; f < 8; f++) byp(t, (t * 3 + f + m) % 8, m, f);

    // R4/R5: fill to capacity, then a refused insert
    fill4();
    ins1("R4 over", 0, 50, 16'h5500);

    // R2: queue not empty always denies
    for (int t = 0; t < 2; t++)
      for (int m = 0; m < 4; m++)
        for (int f = 1; f < 8; f += 3) byp(t, (f + m) % 8, m, f);

    // R5/R6: drain in order, then pop on empty
    drain("R5 drain");
    step("R6 pop empty", 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0);

    // R7: delete a middle entry, then a missing one
    fill4();
    step("R7 rm hit", 0, 0, 0, 1, 1, 20, 0, 0, 0, 0, 0);
    step("R7 rm miss", 0, 0, 0, 1, 0, 20, 0, 0, 0, 0, 0);
    step("R7 rm head", 0, 0, 0, 1, 0, 10, 0, 0, 0, 0, 0);
    drain("R7 drain");

    // R8: squash sweep over thread and squash point
    for (int st = 0; st < 2; st++) begin
      for (int k = 0; k < 5; k++) begin
        fill4();
        step("R8 squash", 1, st, k * 10 + 5 - ((k == 2) ? 5 : 0), 0, 0, 0, 0, 0, 0, 0, 0);
        drain("R8 drain");
      end
    end

    // R9: squash with insert in the same cycle
    fill4();
    step("R9 young drop", 1, 0, 15, 0, 0, 0, 0, 1, 0, 50, 16'h5050);
    fill4();
    step("R9 freed slot", 1, 1, 5, 0, 0, 0, 0, 1, 0, 60, 16'h6060);
    drain("R9 drain");

    // R10: ranking of squash, delete and pop
    fill4();
    step("R10 sq+rm+pop", 1, 1, 25, 1, 0, 10, 1, 0, 0, 0, 0);
    step("R10 rm+pop", 0, 0, 0, 1, 0, 30, 1, 0, 0, 0, 0);
    step("R10 rm miss+pop", 0, 0, 0, 1, 1, 99, 1, 0, 0, 0, 0);
    drain("R10 drain");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule